// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit virtual address into a physical address. It walks a two-level page table that sits in a word-addressed memory. A request brings three things: the virtual address, a read/write flag and the page-table base register of the current address space. The walker reads the root-level entry first. If that entry is present, it reads the leaf entry it points to. It then answers with either a physical address or a fault code.

The virtual address is split into three fields. The top 10 bits index the root table. The next 10 bits index the leaf table. The low 12 bits are the offset inside a 4 KiB page.

Every entry is one 32-bit word with this layout:

| Bits | Field |
|------|-------|
| 0 | present |
| 1 | modified |
| 2 | used |
| 3 | writable |
| 31:12 | frame number |

When a translation succeeds, the walker updates the leaf entry in memory. It sets the used bit on every access, and the modified bit as well on a write. This write-back happens only when the stored word actually changes.

The walker handles one translation at a time. The table memory must return read data in the cycle after it samples a read strobe.

Top module: `pt_walker`

## Requirements
- R1: During and after a synchronous reset, req_ready is 1, and resp_valid, mem_rd_en and mem_wr_en are 0.
- R2: In the cycle after a request is accepted (req_valid and req_ready both high at a rising edge), the walker issues one root read. Its word address is {req_ptbr[31:12], req_vaddr[31:22]}. Bits 11:0 of req_ptbr have no effect.
- R3: If bit 0 (present) of the root entry is 0, the walker makes no second read. It responds with status 2'b01 (page fault) and a zero address, with resp_valid visible two cycles after acceptance.
- R4: If the root entry is present, a leaf read at word address {root[31:12], req_vaddr[21:12]} is issued two cycles after acceptance. If bit 0 of that leaf entry is 0, the response is status 2'b01 with a zero address, four cycles after acceptance.
- R5: A write request to a present leaf whose bit 3 (writable) is 0 returns status 2'b10 (protection fault) with a zero address and no write-back. A read request to such a page succeeds.
- R6: A successful translation returns status 2'b00 and resp_paddr = {leaf[31:12], req_vaddr[11:0]}, four cycles after acceptance. The status value 2'b11 never appears.
- R7: On success, the walker writes the leaf entry back to the leaf's word address. The written word has bit 2 (used) set, and bit 1 (modified) set too for a write; all other bits are unchanged. mem_wr_en is high in the same cycle as resp_valid.
- R8: When the updated entry equals the stored one, no write is issued.
- R9: req_ready is low from acceptance through the response cycle. A request held during that time is not taken, and causes no memory access.
- R10: resp_valid and mem_rd_en are single-cycle pulses, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_ptbr | input | 32 | Page-table base; bits 31:12 give the root table frame |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| resp_paddr | output | 32 | Physical address, zero on a fault |
| mem_rd_en | output | 1 | Table memory read strobe |
| mem_wr_en | output | 1 | Table memory write strobe |
| mem_addr | output | 30 | Table memory word address |
| mem_wdata | output | 32 | Entry written back |
| mem_rdata | input | 32 | Read data, valid the cycle after the read strobe |

## Verification
The latency of each result is counted in rising edges after the accepting edge:

| Result | Due at |
|--------|--------|
| Root read | edge 0 |
| Leaf read | edge 2 |
| Root fault | edge 2 |
| Leaf outcome and its write-back | edge 4 |

The bench samples on falling edges and counts the falling edges that follow acceptance. At those counts it compares the read address, the response and the write strobe with values it derives from its own copy of the tables. The count at which resp_valid appears is itself checked against 2 or 4. One falling edge after the response, the bench confirms that the response has dropped. At the next falling edge it checks the counts of reads and writes made during the walk, and the stored entry, so that a missing or extra access or a wrong write-back is caught.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Response codes
  typedef enum logic [1:0] {
    ST_OK         = 2'b00,
    ST_PAGE_FAULT = 2'b01,
    ST_PROT_FAULT = 2'b10
  } walk_status_e;

  // Walk sequencing
  typedef enum logic [2:0] {
    W_IDLE,
    W_ROOT_WAIT,
    W_ROOT_CHK,
    W_LEAF_WAIT,
    W_LEAF_CHK,
    W_RESP
  } walk_state_e;

  // Entry flag positions
  localparam int unsigned PTE_PRESENT_BIT = 0;
  localparam int unsigned PTE_MOD_BIT     = 1;
  localparam int unsigned PTE_USED_BIT    = 2;
  localparam int unsigned PTE_WRITE_BIT   = 3;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 10,
  parameter int FRAME_W = 20,
  localparam int WADDR_W = FRAME_W + IDX_W,
  localparam int PA_W    = FRAME_W + OFF_W
) (
  input  logic [IDX_W-1:0]   root_idx,
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [IDX_W-1:0]   leaf_idx,
  input  logic [OFF_W-1:0]   page_off,
  input  logic [FRAME_W-1:0] table_frame,
  output logic [WADDR_W-1:0] root_waddr,
  output logic [WADDR_W-1:0] leaf_waddr,
  output logic [PA_W-1:0]    phys_addr
);

  // The root entry sits in the frame named by the base register.
  assign root_waddr = {base_frame, root_idx};

  // The leaf entry sits in the frame named by the root entry.
  assign leaf_waddr = {table_frame, leaf_idx};

  // The page offset passes through unchanged.
  assign phys_addr  = {table_frame, page_off};

endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check
  import pt_walker_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter bit LEAF  = 1'b1
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_write,
  output logic [1:0]       status,
  output logic [PTE_W-1:0] new_entry,
  output logic             need_wb
);

  generate
    if (LEAF) begin : g_leaf
      logic [PTE_W-1:0] set_mask;

      always_comb begin
        set_mask = '0;
        set_mask[PTE_USED_BIT] = 1'b1;
        set_mask[PTE_MOD_BIT]  = is_write;
      end

      always_comb begin
        if (!entry[PTE_PRESENT_BIT]) begin
          status = ST_PAGE_FAULT;
        end else if (is_write && !entry[PTE_WRITE_BIT]) begin
          status = ST_PROT_FAULT;
        end else begin
          status = ST_OK;
        end
      end

      assign new_entry = entry | set_mask;
      assign need_wb   = (status == ST_OK) && (new_entry != entry);

    end else begin : g_root
      // A root entry is checked only for presence and is never updated.
      logic unused_root;
      assign unused_root = ^{entry, is_write};
      assign status    = entry[PTE_PRESENT_BIT] ? ST_OK : ST_PAGE_FAULT;
      assign new_entry = entry;
      assign need_wb   = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32,
  localparam int IDX_W   = (VA_W - OFF_W) / 2,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int WADDR_W = FRAME_W + IDX_W,
  localparam int LOW_W   = IDX_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic [PA_W-1:0]    req_ptbr,
  output logic               resp_valid,
  output logic [1:0]         resp_status,
  output logic [PA_W-1:0]    resp_paddr,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [PTE_W-1:0]   mem_wdata,
  input  logic [PTE_W-1:0]   mem_rdata
);

  walk_state_e       state;
  logic [LOW_W-1:0]  vlow_q;
  logic              write_q;

  logic [WADDR_W-1:0] root_waddr;
  logic [WADDR_W-1:0] leaf_waddr;
  logic [PA_W-1:0]    phys_addr;
  logic [FRAME_W-1:0] rd_frame;

  logic [1:0]         root_status;
  logic [PTE_W-1:0]   root_new_unused;
  logic               root_wb_unused;
  logic [1:0]         leaf_status;
  logic [PTE_W-1:0]   leaf_new;
  logic               leaf_wb;

  logic unused_ptbr;
  assign unused_ptbr = ^req_ptbr[OFF_W-1:0] ^ ^req_vaddr[LOW_W-1:0]
                     ^ root_wb_unused ^ ^root_new_unused;

  assign rd_frame  = mem_rdata[PTE_W-1 -: FRAME_W];
  assign req_ready = (state == W_IDLE);

  pt_addr_gen #(
    .OFF_W   (OFF_W),
    .IDX_W   (IDX_W),
    .FRAME_W (FRAME_W)
  ) u_addr (
    .root_idx    (req_vaddr[VA_W-1 -: IDX_W]),
    .base_frame  (req_ptbr[PA_W-1 -: FRAME_W]),
    .leaf_idx    (vlow_q[LOW_W-1 -: IDX_W]),
    .page_off    (vlow_q[OFF_W-1:0]),
    .table_frame (rd_frame),
    .root_waddr  (root_waddr),
    .leaf_waddr  (leaf_waddr),
    .phys_addr   (phys_addr)
  );

  pt_pte_check #(
    .PTE_W (PTE_W),
    .LEAF  (1'b0)
  ) u_root_chk (
    .entry     (mem_rdata),
    .is_write  (write_q),
    .status    (root_status),
    .new_entry (root_new_unused),
    .need_wb   (root_wb_unused)
  );

  pt_pte_check #(
    .PTE_W (PTE_W),
    .LEAF  (1'b1)
  ) u_leaf_chk (
    .entry     (mem_rdata),
    .is_write  (write_q),
    .status    (leaf_status),
    .new_entry (leaf_new),
    .need_wb   (leaf_wb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= W_IDLE;
      vlow_q      <= '0;
      write_q     <= 1'b0;
      resp_valid  <= 1'b0;
      resp_status <= ST_OK;
      resp_paddr  <= '0;
      mem_rd_en   <= 1'b0;
      mem_wr_en   <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_rd_en  <= 1'b0;
      mem_wr_en  <= 1'b0;
      case (state)
        W_IDLE: begin
          if (req_valid) begin
            vlow_q    <= req_vaddr[LOW_W-1:0];
            write_q   <= req_write;
            mem_rd_en <= 1'b1;
            mem_addr  <= root_waddr;
            state     <= W_ROOT_WAIT;
          end
        end
        W_ROOT_WAIT: state <= W_ROOT_CHK;
        W_ROOT_CHK: begin
          if (root_status != ST_OK) begin
            resp_valid  <= 1'b1;
            resp_status <= ST_PAGE_FAULT;
            resp_paddr  <= '0;
            state       <= W_RESP;
          end else begin
            mem_rd_en <= 1'b1;
            mem_addr  <= leaf_waddr;
            state     <= W_LEAF_WAIT;
          end
        end
        W_LEAF_WAIT: state <= W_LEAF_CHK;
        W_LEAF_CHK: begin
          resp_valid  <= 1'b1;
          resp_status <= leaf_status;
          resp_paddr  <= (leaf_status == ST_OK) ? phys_addr : '0;
          if (leaf_wb) begin
            mem_wr_en <= 1'b1;
            mem_wdata <= leaf_new;
          end
          state <= W_RESP;
        end
        W_RESP:  state <= W_IDLE;
        default: state <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 32,
  parameter int PTE_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic [1:0]       resp_status,
  input logic [PA_W-1:0]  resp_paddr,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [PTE_W-1:0] mem_wdata
);

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R10
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R10
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R10
  AST_BUSY_AT_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !req_ready); // R9
  AST_NO_READ_AT_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !mem_rd_en); // R9
  AST_ACCEPT_READS_ROOT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_en && !req_ready)); // R2
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status != 2'b00) |-> (resp_paddr == '0)); // R3
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_status != 2'b11)); // R6
  AST_WB_ONLY_ON_OK: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (resp_valid && resp_status == 2'b00)); // R7
  AST_WB_USED_SET: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> mem_wdata[2]); // R7

endmodule

bind pt_walker pt_walker_chk #(
  .PA_W  (PA_W),
  .PTE_W (PTE_W)
) u_pt_walker_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .resp_status (resp_status),
  .resp_paddr  (resp_paddr),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .mem_wdata   (mem_wdata)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic [31:0] req_ptbr;
  logic        resp_valid;
  logic [1:0]  resp_status;
  logic [31:0] resp_paddr;
  logic        mem_rd_en;
  logic        mem_wr_en;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_ptbr(req_ptbr),
    .resp_valid(resp_valid), .resp_status(resp_status), .resp_paddr(resp_paddr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Table memory model: one-cycle read latency
  logic [31:0] tbl [logic [29:0]];
  int rd_cnt = 0;
  int wr_cnt = 0;
  int n_chk  = 0;
  int n_err  = 0;

  function automatic logic [31:0] tbl_rd(input logic [29:0] k);
    if (tbl.exists(k)) return tbl[k];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= tbl_rd(mem_addr);
      rd_cnt++;
    end
    if (mem_wr_en) begin
      tbl[mem_addr] = mem_wdata;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Expected outcome, derived from the requirements
  function automatic void model_walk(
    input  logic [31:0] va, input logic wr, input logic [31:0] ptbr,
    output logic [1:0] st, output logic [31:0] pa, output int lat,
    output int nrd, output bit wb, output logic [29:0] rk,
    output logic [29:0] lk, output logic [31:0] nw);
    logic [31:0] re;
    logic [31:0] le;
    rk = {ptbr[31:12], va[31:22]};
    re = tbl_rd(rk);
    lk = '0; nw = '0; wb = 1'b0; pa = '0;
    if (!re[0]) begin
      st = 2'b01; lat = 2; nrd = 1;
      return;
    end
    lk = {re[31:12], va[21:12]};
    le = tbl_rd(lk);
    lat = 4; nrd = 2;
    if (!le[0]) begin
      st = 2'b01;
    end else if (wr && !le[3]) begin
      st = 2'b10;
    end else begin
      st = 2'b00;
      pa = {le[31:12], va[11:0]};
      nw = le | 32'h4 | (wr ? 32'h2 : 32'h0);
      wb = (nw != le);
    end
  endfunction

  task automatic walk(input logic [31:0] va, input logic wr,
                      input logic [31:0] ptbr, input bit poke);
    logic [1:0]  st;
    logic [31:0] pa;
    logic [29:0] rk;
    logic [29:0] lk;
    logic [31:0] nw;
    int lat;
    int nrd;
    bit wb;
    int n;
    int r0;
    int w0;
    bit busy_ok;
    model_walk(va, wr, ptbr, st, pa, lat, nrd, wb, rk, lk, nw);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_ptbr = ptbr;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    n = 0;
    busy_ok = 1'b1;
    // Hold a different request during the walk when asked
    req_valid = poke;
    req_vaddr = ~va;
    chk(mem_rd_en && mem_addr == rk, "R2", "root read address",
        64'(mem_addr), 64'(rk));
    while (!resp_valid && n < 20) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      n++;
      if (n == 2 && lat == 4)
        chk(mem_rd_en && mem_addr == lk, "R4", "leaf read address",
            64'(mem_addr), 64'(lk));
    end
    chk(busy_ok && !req_ready, "R9", "ready low while busy", 64'(busy_ok), 64'd1);
    chk(n == lat, (lat == 2) ? "R3" : "R6", "response latency", 64'(n), 64'(lat));
    chk(resp_status == st, (st == 2'b10) ? "R5" : (lat == 2 ? "R3" : "R4"),
        "status", 64'(resp_status), 64'(st));
    chk(resp_paddr == pa, "R6", "physical address", 64'(resp_paddr), 64'(pa));
    chk(mem_wr_en == wb, wb ? "R7" : "R8", "write strobe", 64'(mem_wr_en), 64'(wb));
    if (wb)
      chk(mem_addr == lk && mem_wdata == nw, "R7", "write-back word",
          64'(mem_wdata), 64'(nw));
    req_valid = 1'b0;
    @(negedge clk);
    chk(!resp_valid, "R10", "response one cycle", 64'(resp_valid), 64'd0);
    @(negedge clk);
    chk(rd_cnt - r0 == nrd, "R9", "reads per walk", 64'(rd_cnt - r0), 64'(nrd));
    chk(wr_cnt - w0 == int'(wb), "R8", "writes per walk", 64'(wr_cnt - w0), 64'(wb));
    if (wb)
      chk(tbl_rd(lk) == nw, "R7", "stored entry", 64'(tbl_rd(lk)), 64'(nw));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] VA   = {10'd3, 10'd5, 12'habc};
  localparam logic [29:0] RKEY = {20'h00010, 10'd3};
  localparam logic [29:0] LKEY = {20'h00200, 10'd5};

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_ptbr = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_rd_en && !mem_wr_en, "R1", "state in reset",
        64'({req_ready, resp_valid, mem_rd_en, mem_wr_en}), 64'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_rd_en && !mem_wr_en, "R1", "state after reset",
        64'({req_ready, resp_valid, mem_rd_en, mem_wr_en}), 64'h8);

    // R3: root entry absent
    walk(VA, 1'b0, BASE, 1'b0);
    // R4: leaf absent; ptbr low bits set to show R2 ignores them
    tbl[RKEY] = {20'h00200, 12'h001};
    walk(VA, 1'b0, BASE | 32'h0000_0fff, 1'b0);
    // R5: write to read-only page
    tbl[LKEY] = {20'h12345, 12'h001};
    walk(VA, 1'b1, BASE, 1'b0);
    // R5/R7: read of read-only page sets used bit
    walk(VA, 1'b0, BASE, 1'b0);
    // R8: repeated read leaves entry alone
    walk(VA, 1'b0, BASE, 1'b0);
    // R7: write to writable page, request held while busy (R9)
    tbl[LKEY] = {20'h0beef, 12'h009};
    walk(VA, 1'b1, BASE, 1'b1);
    // R8: repeated write, bits already set
    walk(VA, 1'b1, BASE, 1'b0);

    // Random walks
    for (int i = 0; i < 80; i++) begin
      logic [31:0] va;
      logic [31:0] ptbr;
      logic [31:0] re;
      logic [31:0] le;
      va   = $urandom;
      ptbr = {(($urandom % 2) == 0) ? 20'h00010 : 20'h00020, 12'($urandom)};
      re   = {20'h00400 + 20'($urandom % 64), 11'h0, 1'(($urandom % 4) != 0)};
      le   = {20'($urandom), 8'h0, 4'($urandom)};
      le[0] = (($urandom % 5) != 0);
      tbl[{ptbr[31:12], va[31:22]}] = re;
      if (re[0]) tbl[{re[31:12], va[21:12]}] = le;
      walk(va, 1'($urandom), ptbr, 1'(($urandom % 4) == 0));
      if (($urandom % 3) == 0) walk(va, 1'b0, ptbr, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule